// File: doc/BRIEF.md
# ADC Result Window Watchdog

This block sits beside an ADC sequencer and checks every conversion result the sequencer hands out. Each result arrives with a valid strobe, the number of the channel it came from and the converted value. The block tests the value against a programmable upper and lower bound. A value outside that band is an excursion.

A guard-mode select chooses the results that are checked. In the first mode every channel is guarded. In the second mode only one chosen channel is guarded, and results from all other channels pass unchecked. An excursion sets a sticky status flag, which software clears with a pulse. The interrupt output shows the flag gated by an interrupt enable. While a scan is in progress and the interrupt enable is set, an excursion also raises a one-cycle request to abort the scan. With the enable clear, the scan is left to finish.

Top module: `awd_watch`

## Requirements
- R1: Directly after reset, `alarm_flag`, `alarm_irq` and `scan_abort` are all 0.
- R2: A result is an excursion when its 12-bit unsigned value is strictly above `limit_hi` or strictly below `limit_lo`. A value equal to either bound is inside the band.
- R3: A qualifying excursion presented with `res_valid` high sets `alarm_flag` at the next rising clock edge. The flag then stays set until it is cleared.
- R4: With `guard_one` = 1, only results whose `res_chan` equals `guard_chan` are checked. A result from any other channel leaves the flag and the abort output unchanged.
- R5: With `guard_one` = 0, results from every channel are checked.
- R6: Inputs presented while `res_valid` is 0 never set the flag and never request an abort.
- R7: `alarm_irq` equals `alarm_flag` AND `irq_en` at all times.
- R8: When `scan_active` and `irq_en` are both 1 and a qualifying excursion is presented, `scan_abort` is 1 for exactly the following cycle.
- R9: When `irq_en` or `scan_active` is 0, an excursion still sets the flag but `scan_abort` stays 0.
- R10: A `flag_clr` pulse clears `alarm_flag` at the next edge. If an excursion is presented in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | Conversion result strobe |
| res_chan | input | 5 | Channel number of the result |
| res_data | input | 12 | Converted value |
| limit_hi | input | 12 | Upper bound of the allowed band |
| limit_lo | input | 12 | Lower bound of the allowed band |
| guard_one | input | 1 | 1: guard only `guard_chan`; 0: guard every channel |
| guard_chan | input | 5 | Channel guarded in single-channel mode |
| irq_en | input | 1 | Interrupt enable; also gates the abort request |
| scan_active | input | 1 | A scan is in progress |
| flag_clr | input | 1 | Clear pulse for the sticky flag |
| alarm_flag | output | 1 | Sticky excursion flag |
| alarm_irq | output | 1 | Watchdog interrupt |
| scan_abort | output | 1 | One-cycle scan abort request |

## Verification
The flag and the abort request come from registers, so each is due one rising edge after the result that causes it. The interrupt is combinational from the flag and `irq_en`, so it follows the flag in that same cycle. The bench drives a new input set on each falling edge and waits for the next rising edge. It samples one time unit later and compares the outputs with a reference model that was stepped for that one edge. Every check therefore looks at exactly one cycle of latency, and a later or earlier response from the design shows up as a mismatch.

// File: rtl/awd_pkg.sv
package awd_pkg;

    parameter int DATA_W = 12;
    parameter int CHAN_W = 5;

    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic [DATA_W-1:0] data;
    } awd_result_t;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } awd_band_t;

    typedef enum logic {
        GUARD_ALL = 1'b0,
        GUARD_ONE = 1'b1
    } awd_guard_e;

    function automatic logic outside_band(input logic [DATA_W-1:0] v,
                                          input awd_band_t b);
        return (v > b.hi) || (v < b.lo);
    endfunction

endpackage

// File: rtl/awd_chan_filter.sv
module awd_chan_filter
    import awd_pkg::*;
(
    input  awd_result_t       res,
    input  awd_guard_e        mode,
    input  logic [CHAN_W-1:0] sel_chan,
    output logic              take
);
    logic chan_hit;

    always_comb begin
        chan_hit = (res.chan == sel_chan);
        case (mode)
            GUARD_ONE: take = res.valid && chan_hit;
            default:   take = res.valid;
        endcase
    end
endmodule

// File: rtl/awd_window_cmp.sv
module awd_window_cmp
    import awd_pkg::*;
(
    input  logic [DATA_W-1:0] value,
    input  awd_band_t         band,
    input  logic              take,
    output logic              excursion
);
    logic out_of_band;

    always_comb begin
        out_of_band = outside_band(value, band);
        excursion   = take && out_of_band;
    end
endmodule

// File: rtl/awd_flag_ctrl.sv
module awd_flag_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic excursion,
    input  logic clr,
    input  logic irq_en,
    input  logic scan_active,
    output logic flag,
    output logic irq,
    output logic abort_req
);
    logic flag_q;
    logic abort_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            if (excursion)
                flag_q <= 1'b1;
            else if (clr)
                flag_q <= 1'b0;
            abort_q <= excursion && irq_en && scan_active;
        end
    end

    assign flag      = flag_q;
    assign irq       = flag_q && irq_en;
    assign abort_req = abort_q;

    p_set_next_r3: assert property (@(posedge clk) disable iff (rst)
        excursion |=> flag_q);

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr && !excursion) |=> !flag_q);

    p_abort_gated_r9: assert property (@(posedge clk) disable iff (rst)
        (!irq_en || !scan_active) |=> !abort_q);

    p_abort_flag_r8: assert property (@(posedge clk) disable iff (rst)
        abort_q |-> flag_q);

    p_irq_flag_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag_q);
endmodule

// File: rtl/awd_watch.sv
module awd_watch
    import awd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              res_valid,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] limit_hi,
    input  logic [DATA_W-1:0] limit_lo,
    input  logic              guard_one,
    input  logic [CHAN_W-1:0] guard_chan,
    input  logic              irq_en,
    input  logic              scan_active,
    input  logic              flag_clr,
    output logic              alarm_flag,
    output logic              alarm_irq,
    output logic              scan_abort
);
    awd_result_t res;
    awd_band_t   band;
    awd_guard_e  mode;
    logic        take;
    logic        excursion;

    always_comb begin
        res.valid = res_valid;
        res.chan  = res_chan;
        res.data  = res_data;
        band.hi   = limit_hi;
        band.lo   = limit_lo;
        mode      = guard_one ? GUARD_ONE : GUARD_ALL;
    end

    awd_chan_filter u_filter (
        .res      (res),
        .mode     (mode),
        .sel_chan (guard_chan),
        .take     (take)
    );

    awd_window_cmp u_cmp (
        .value     (res.data),
        .band      (band),
        .take      (take),
        .excursion (excursion)
    );

    awd_flag_ctrl u_flag (
        .clk         (clk),
        .rst         (rst),
        .excursion   (excursion),
        .clr         (flag_clr),
        .irq_en      (irq_en),
        .scan_active (scan_active),
        .flag        (alarm_flag),
        .irq         (alarm_irq),
        .abort_req   (scan_abort)
    );

    p_invalid_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !alarm_flag && !flag_clr) |=> (!alarm_flag && !scan_abort));

    p_other_chan_r4: assert property (@(posedge clk) disable iff (rst)
        (guard_one && res_chan != guard_chan && !alarm_flag && !flag_clr)
        |=> (!alarm_flag && !scan_abort));

    p_take_valid_r6: assert property (@(posedge clk) disable iff (rst)
        take |-> res_valid);
endmodule

// File: tb/sim_awd_watch.sv
module sim_awd_watch;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        res_valid;
    logic [4:0]  res_chan;
    logic [11:0] res_data;
    logic [11:0] limit_hi;
    logic [11:0] limit_lo;
    logic        guard_one;
    logic [4:0]  guard_chan;
    logic        irq_en;
    logic        scan_active;
    logic        flag_clr;
    logic        alarm_flag;
    logic        alarm_irq;
    logic        scan_abort;

    int checks = 0;
    int errors = 0;
    logic m_flag = 1'b0;
    logic m_abort = 1'b0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    awd_watch u0 (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .limit_hi(limit_hi), .limit_lo(limit_lo),
        .guard_one(guard_one), .guard_chan(guard_chan), .irq_en(irq_en),
        .scan_active(scan_active), .flag_clr(flag_clr),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq), .scan_abort(scan_abort)
    );

    function automatic bit ref_exc();
        bit sel;
        sel = res_valid && (!guard_one || res_chan == guard_chan);
        return sel && ((res_data > limit_hi) || (res_data < limit_lo));
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int ch, input int d, input bit clr);
        @(negedge clk);
        res_valid = v;
        res_chan  = 5'(ch);
        res_data  = 12'(d);
        flag_clr  = clr;
    endtask

    // advance one edge; model steps, then outputs are compared
    task automatic step(input string tag);
        bit e;
        e = ref_exc();
        if (e) m_flag = 1'b1;
        else if (flag_clr) m_flag = 1'b0;
        m_abort = e && irq_en && scan_active;
        @(posedge clk);
        #1;
        chk({tag, " flag"},  alarm_flag, m_flag);
        chk({tag, " abort"}, scan_abort, m_abort);
        chk({"R7 ", tag, " irq"}, alarm_irq, m_flag && irq_en);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; res_valid = 0; res_chan = 0; res_data = 0;
        limit_hi = 12'd3000; limit_lo = 12'd1000; guard_one = 0;
        guard_chan = 5'd7; irq_en = 1; scan_active = 1; flag_clr = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 flag", alarm_flag, 1'b0);
        chk("R1 abort", scan_abort, 1'b0);
        chk("R1 irq", alarm_irq, 1'b0);
        @(negedge clk); rst = 1'b0;

        // R2 boundaries: equal to bounds are inside
        drive(1, 3, 3000, 0); step("R2 eq hi");
        drive(1, 3, 1000, 0); step("R2 eq lo");
        drive(0, 3, 4000, 0); step("R6 invalid");
        drive(1, 3, 3001, 0); step("R2 R3 R8 hi+1");
        drive(0, 3, 0, 0);    step("R3 sticky");
        drive(0, 3, 0, 1);    step("R10 clear");
        drive(1, 3, 999, 0);  step("R2 R5 lo-1");
        // R10 collision: excursion wins over clear
        drive(1, 9, 4095, 1); step("R10 collide");
        drive(0, 0, 0, 1);    step("R10 clear2");

        // R4 single channel guard
        guard_one = 1;
        drive(1, 8, 4095, 0); step("R4 other chan");
        drive(1, 7, 4095, 0); step("R4 match chan");
        drive(0, 0, 0, 1);    step("R10 clear3");

        // R9 abort gating
        guard_one = 0; irq_en = 0;
        drive(1, 2, 0, 0);    step("R9 no irq_en");
        drive(0, 0, 0, 1);    step("R10 clear4");
        irq_en = 1; scan_active = 0;
        drive(1, 2, 0, 0);    step("R9 no scan");
        scan_active = 1;
        drive(1, 2, 0, 0);    step("R8 abort on");
        drive(0, 2, 0, 0);    step("R8 abort one cycle");

        // random mix
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            res_valid   = 1'($urandom);
            res_chan    = 5'($urandom_range(0, 9));
            res_data    = 12'($urandom);
            guard_one   = 1'($urandom);
            guard_chan  = 5'($urandom_range(0, 9));
            irq_en      = 1'($urandom);
            scan_active = 1'($urandom);
            flag_clr    = ($urandom_range(0, 3) == 0);
            limit_lo    = 12'($urandom_range(0, 2000));
            limit_hi    = 12'($urandom_range(2000, 4095));
            step("R3 R4 R5 R8 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule